// File: doc/BRIEF.md
# Three-Width One-Pulse-Per-Second Divider

This block divides a reference clock down to one pulse per second and drives three outputs from that one time base. All three outputs rise on the same clock at the start of every second. They then fall at three fixed points: a short marker after 100 us, a medium marker after 10 ms, and a square wave that falls at the half-second. The reference frequency is a parameter, `CLK_HZ`, and every count is derived from it. The period is `CLK_HZ` clocks, and the high times are `CLK_HZ/10000`, `CLK_HZ/100` and `CLK_HZ/2` clocks.

Two asynchronous inputs let a user align the second to an outside event. An active-low arm request is taken only near the start of a period, while the short marker is high. Once it is taken, the divider freezes with all outputs high. The next rising edge on the sync input then starts a new second. Both inputs pass through `SYNC_STAGES` flip-flops. The restart loads the phase counter past the start, by the fixed input latency, so the new second counts from the first clock edge after the sync edge.

Top module: `pps_multi_divider`

## Requirements
- R1: While `rst` is high all three outputs are low. On the first clock edge after `rst` falls, all three outputs go high and a period begins.
- R2: Once running and not halted, a rising edge of `pps_fast` recurs every `CLK_HZ` clocks.
- R3: `pps_fast` stays high for exactly `CLK_HZ/10000` clocks from the period start, then stays low for the rest of the period.
- R4: `pps_mid` stays high for exactly `CLK_HZ/100` clocks from the period start, then stays low for the rest of the period.
- R5: `pps_sq` stays high for exactly `CLK_HZ/2` clocks from the period start, then stays low for the rest of the period.
- R6: The three outputs rise in the same clock cycle.
- R7: An arm request (`arm_n` = 0) is accepted if, after `SYNC_STAGES` clocks of synchronizer delay, it is seen while `pps_fast` is high. On acceptance the divider halts and all three outputs stay high.
- R8: An arm request that is seen only while `pps_fast` is low is ignored, and the outputs keep their normal timing.
- R9: While halted, a rising edge on `sync_in` restarts the period. Take edge 1 as the first clock edge after the sync edge. `pps_fast`, `pps_mid` and `pps_sq` are then high after edges 1 through W and low after edge W+1, where W is their width. The next period starts at edge `CLK_HZ`+1.
- R10: Releasing `arm_n` while halted does not resume counting. The outputs stay high until a sync rising edge.
- R11: Rising edges on `sync_in` while the divider is running and not halted have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, `CLK_HZ` Hz |
| rst | input | 1 | Synchronous power-on reset, active high |
| arm_n | input | 1 | Asynchronous arm request, active low |
| sync_in | input | 1 | Asynchronous restart strobe; its rising edge counts |
| pps_fast | output | 1 | Once-per-second pulse, 100 us wide |
| pps_mid | output | 1 | Once-per-second pulse, 10 ms wide |
| pps_sq | output | 1 | One-hertz square wave, 50% duty |

## Verification
The main function is exercised with free-running periods with no input activity, which separates period length errors from width errors on each of the three outputs. It is also driven with an arm pulse placed well after the start marker, which must be ignored, and with sync strobes during normal running, which must also be ignored. Finally it is driven with an arm held across a period boundary, then released, then followed by a sync edge. That last pattern checks the acceptance window, the frozen-high hold and the latency compensation. An off-by-one in the restart load shows up as every restarted edge moving by one clock. A cycle-accurate behavioural model in the bench is compared with all three outputs on every clock.

// File: rtl/pps_div_pkg.sv
package pps_div_pkg;

    // Operating mode of the phase controller
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,   // held in reset, outputs low
        MODE_RUN  = 2'd1,   // counting through the second
        MODE_HALT = 2'd2    // armed, frozen with outputs high
    } mode_e;

    localparam int unsigned N_PULSES = 3;

endpackage

// File: rtl/pps_sync_chain.sv
module pps_sync_chain #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign sh_d[i] = din;
        end else begin : g_next
            assign sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/pps_rise_det.sv
module pps_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/pps_phase_ctrl.sv
module pps_phase_ctrl
    import pps_div_pkg::*;
#(
    parameter int unsigned PERIOD     = 5000000,
    parameter int unsigned ARM_WIN    = 500,
    parameter int unsigned RESTART_PH = 2,
    parameter int unsigned CW         = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_n_s,
    input  logic          sync_rise,
    output logic [CW-1:0] phase_o,
    output logic          live_o,
    output logic          hold_o
);

    localparam logic [CW-1:0] LAST_PH     = CW'(PERIOD - 1);
    localparam logic [CW-1:0] ARM_LIM     = CW'(ARM_WIN);
    localparam logic [CW-1:0] RESTART_CNT = CW'(RESTART_PH);

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            MODE_IDLE: begin
                st_d.mode = MODE_RUN;
                st_d.cnt  = '0;
            end
            MODE_RUN: begin
                if (!arm_n_s && (st_q.cnt < ARM_LIM)) begin
                    st_d.mode = MODE_HALT;
                end else if (st_q.cnt == LAST_PH) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            MODE_HALT: begin
                if (sync_rise) begin
                    st_d.mode = MODE_RUN;
                    st_d.cnt  = RESTART_CNT;
                end
            end
            default: begin
                st_d.mode = MODE_IDLE;
                st_d.cnt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_IDLE;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.cnt;
    assign live_o  = (st_q.mode != MODE_IDLE);
    assign hold_o  = (st_q.mode == MODE_HALT);

    // R2
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (live_o && !hold_o && st_q.cnt == LAST_PH) |=> (st_q.cnt == '0));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && !sync_rise) |=> (hold_o && $stable(st_q.cnt)));

    // R9
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && sync_rise) |=> (!hold_o && st_q.cnt == RESTART_CNT));

    // R8
    arm_window_chk: assert property (@(posedge clk) disable iff (rst)
        (live_o && !hold_o && st_q.cnt >= ARM_LIM) |=> !hold_o);

endmodule

// File: rtl/pps_width_cmp.sv
module pps_width_cmp #(
    parameter int unsigned CW       = 23,
    parameter int unsigned HIGH_CNT = 500
) (
    input  logic [CW-1:0] phase_i,
    input  logic          live_i,
    input  logic          hold_i,
    output logic          pulse_o
);

    localparam logic [CW-1:0] LIM = CW'(HIGH_CNT);

    always_comb begin
        pulse_o = live_i && (hold_i || (phase_i < LIM));
    end

endmodule

// File: rtl/pps_multi_divider.sv
module pps_multi_divider
    import pps_div_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 5000000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_n,
    input  logic sync_in,
    output logic pps_fast,
    output logic pps_mid,
    output logic pps_sq
);

    localparam int unsigned CW     = $clog2(CLK_HZ);
    localparam int unsigned W_FAST = CLK_HZ / 10000;
    localparam int unsigned W_MID  = CLK_HZ / 100;
    localparam int unsigned W_SQ   = CLK_HZ / 2;
    localparam int unsigned WIDTHS [N_PULSES] = '{W_FAST, W_MID, W_SQ};

    logic          arm_n_s;
    logic          sync_s;
    logic          sync_rise;
    logic [CW-1:0] phase;
    logic          live;
    logic          hold;
    logic [N_PULSES-1:0] pulses;

    pps_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_arm_sync (
        .clk (clk),
        .rst (rst),
        .din (arm_n),
        .dout(arm_n_s)
    );

    pps_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_strobe_sync (
        .clk (clk),
        .rst (rst),
        .din (sync_in),
        .dout(sync_s)
    );

    pps_rise_det u_strobe_edge (
        .clk    (clk),
        .rst    (rst),
        .level_i(sync_s),
        .rise_o (sync_rise)
    );

    pps_phase_ctrl #(
        .PERIOD    (CLK_HZ),
        .ARM_WIN   (W_FAST),
        .RESTART_PH(SYNC_STAGES),
        .CW        (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .arm_n_s  (arm_n_s),
        .sync_rise(sync_rise),
        .phase_o  (phase),
        .live_o   (live),
        .hold_o   (hold)
    );

    for (genvar g = 0; g < N_PULSES; g++) begin : g_width
        pps_width_cmp #(.CW(CW), .HIGH_CNT(WIDTHS[g])) u_cmp (
            .phase_i(phase),
            .live_i (live),
            .hold_i (hold),
            .pulse_o(pulses[g])
        );
    end

    assign pps_fast = pulses[0];
    assign pps_mid  = pulses[1];
    assign pps_sq   = pulses[2];

    // R6
    rise_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pps_fast) |-> (pps_mid && pps_sq));

    // R4
    mid_inside_sq_chk: assert property (@(posedge clk) disable iff (rst)
        pps_mid |-> pps_sq);

    // R3
    fast_inside_mid_chk: assert property (@(posedge clk) disable iff (rst)
        pps_fast |-> pps_mid);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (!pps_fast && !pps_mid && !pps_sq));

endmodule

// File: tb/test_pps_multi_divider.sv
`timescale 1ns/1ps
module test_pps_multi_divider;

    localparam int CLK_HZ = 20000;
    localparam int P      = CLK_HZ;
    localparam int W1     = CLK_HZ / 10000;
    localparam int W2     = CLK_HZ / 100;
    localparam int W3     = CLK_HZ / 2;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_n = 1'b1;
    logic sync_in = 1'b0;
    logic pps_fast, pps_mid, pps_sq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pps_multi_divider #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(LAT)) i_pps_multi_divider (
        .clk(clk), .rst(rst), .arm_n(arm_n), .sync_in(sync_in),
        .pps_fast(pps_fast), .pps_mid(pps_mid), .pps_sq(pps_sq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Behavioural reference model
    bit m_live = 0, m_halt = 0;
    int m_ph = 0;
    bit a_h1 = 1, a_h2 = 1;
    bit s_h1 = 0, s_h2 = 0, s_h3 = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_live = 0; m_halt = 0; m_ph = 0;
            a_h1 = 1; a_h2 = 1; s_h1 = 0; s_h2 = 0; s_h3 = 0;
        end else begin
            if (!m_live) begin
                m_live = 1; m_ph = 0;
            end else if (m_halt) begin
                if (s_h2 && !s_h3) begin
                    m_halt = 0; m_ph = LAT;
                end
            end else if (!a_h2 && m_ph < W1) begin
                m_halt = 1;
            end else begin
                m_ph = (m_ph + 1) % P;
            end
            s_h3 = s_h2; s_h2 = s_h1; s_h1 = sync_in;
            a_h2 = a_h1; a_h1 = arm_n;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        bit ef, em, es;
        ef = m_live && (m_halt || m_ph < W1);
        em = m_live && (m_halt || m_ph < W2);
        es = m_live && (m_halt || m_ph < W3);
        chk(pps_fast === ef, m_halt ? "R7 model pps_fast" : "R3 model pps_fast", int'(pps_fast), int'(ef));
        chk(pps_mid  === em, m_halt ? "R7 model pps_mid"  : "R4 model pps_mid",  int'(pps_mid),  int'(em));
        chk(pps_sq   === es, m_halt ? "R7 model pps_sq"   : "R5 model pps_sq",   int'(pps_sq),   int'(es));
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            failures++;
            $display("FAIL R2 watchdog expired act=%0d exp=%0d", cyc, 190000);
            finish_run();
        end
    end

    // Measure one period; at_rise means the caller already sits on a rise
    task automatic measure_period(input bit at_rise);
        bit prev;
        int n, f_fall, m_fall, s_fall;
        if (!at_rise) begin
            prev = pps_fast;
            forever begin
                @(negedge clk);
                if (pps_fast && !prev) break;
                prev = pps_fast;
            end
        end
        chk(pps_mid && pps_sq, "R6 joint rise", int'({pps_mid, pps_sq}), 3);
        n = 0; f_fall = -1; m_fall = -1; s_fall = -1;
        forever begin
            @(negedge clk);
            n++;
            if (!pps_fast && f_fall < 0) f_fall = n;
            if (!pps_mid  && m_fall < 0) m_fall = n;
            if (!pps_sq   && s_fall < 0) s_fall = n;
            if (pps_fast && f_fall >= 0) break;
            if (n > P + 10) break;
        end
        chk(f_fall == W1, "R3 fast width", f_fall, W1);
        chk(m_fall == W2, "R4 mid width", m_fall, W2);
        chk(s_fall == W3, "R5 square width", s_fall, W3);
        chk(n == P, "R2 period length", n, P);
        chk(pps_mid && pps_sq, "R6 joint rise next", int'({pps_mid, pps_sq}), 3);
    endtask

    initial begin
        int n, f_fall, m_fall, s_fall;
        repeat (5) @(negedge clk);
        chk(!pps_fast && !pps_mid && !pps_sq, "R1 outputs low in reset",
            int'({pps_fast, pps_mid, pps_sq}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pps_fast && pps_mid && pps_sq, "R1 first period starts",
            int'({pps_fast, pps_mid, pps_sq}), 7);
        measure_period(1'b1);

        // R8: late arm pulse is ignored
        repeat (100) @(negedge clk);
        arm_n = 1'b0;
        repeat (300) @(negedge clk);
        arm_n = 1'b1;
        repeat (1000) @(negedge clk);
        chk(!pps_mid && pps_sq && !pps_fast, "R8 late arm ignored",
            int'({pps_fast, pps_mid, pps_sq}), 1);

        // R11: sync strobes while running are ignored
        sync_in = 1'b1;
        repeat (10) @(negedge clk);
        sync_in = 1'b0;
        repeat (100) @(negedge clk);
        chk(!pps_mid && pps_sq && !pps_fast, "R11 sync while running",
            int'({pps_fast, pps_mid, pps_sq}), 1);
        measure_period(1'b0);

        // R7: arm held across a period boundary
        while (!(m_live && !m_halt && m_ph == P - 10)) @(negedge clk);
        arm_n = 1'b0;
        repeat (60) @(negedge clk);
        chk(pps_fast && pps_mid && pps_sq, "R7 halted outputs high",
            int'({pps_fast, pps_mid, pps_sq}), 7);
        repeat (3000) @(negedge clk);
        chk(pps_fast && pps_mid && pps_sq, "R7 halt persists",
            int'({pps_fast, pps_mid, pps_sq}), 7);

        // R10: release arm, still halted
        arm_n = 1'b1;
        repeat (1000) @(negedge clk);
        chk(pps_fast && pps_mid && pps_sq, "R10 release keeps halt",
            int'({pps_fast, pps_mid, pps_sq}), 7);

        // R9: sync edge restarts, referenced to the first edge after it
        sync_in = 1'b1;
        n = 0; f_fall = -1; m_fall = -1; s_fall = -1;
        forever begin
            @(negedge clk);
            n++;
            if (n == 20) sync_in = 1'b0;
            if (!pps_fast && f_fall < 0) f_fall = n;
            if (!pps_mid  && m_fall < 0) m_fall = n;
            if (!pps_sq   && s_fall < 0) s_fall = n;
            if (pps_fast && f_fall >= 0) break;
            if (n > P + 10) break;
        end
        chk(f_fall == W1 + 1, "R9 restart fast fall", f_fall, W1 + 1);
        chk(m_fall == W2 + 1, "R9 restart mid fall", m_fall, W2 + 1);
        chk(s_fall == W3 + 1, "R9 restart square fall", s_fall, W3 + 1);
        chk(n == P + 1, "R9 restart next rise", n, P + 1);
        measure_period(1'b1);

        finish_run();
    end

endmodule